// File: doc/BRIEF.md
# Field-Paged Program Counter with Return Stack

This block produces the instruction address for an 11-bit program space. The address is split into a 3-bit field and an 8-bit up counter. The top two bits of the counter choose a page of 64 words, and the low six bits choose the word. A sequential advance steps only the counter. Execution therefore moves from one page into the next, and at the end of the last page it wraps back to page 0 of the same field. Only a long jump or a long call can change the field.

Beside the program counter, the block keeps a return-address stack three entries deep. Three commands push onto it: a long call, a short call into the first page of field 0, and an interrupt acknowledge. A return pops the top entry back into the program counter. The sequencer around the block raises at most the command it wants in each clock cycle. If several commands are raised together, a fixed priority picks one. Every change takes effect at the next rising clock edge.

Top module: `pc_sequencer`

## Requirements
- R1: After reset `pcAddr` is 0x000 and all three stack entries read 0x000.
- R2: `advance` alone adds one to `pcAddr[7:0]` modulo 256 and leaves `pcAddr[10:8]` unchanged. For example, 0x03F goes to 0x040 and 0x5FF goes to 0x500. With no command raised, `pcAddr` holds its value.
- R3: `jumpLong` loads all 11 bits of `targetLong` into `pcAddr`, including the field bits.
- R4: `jumpPage` replaces `pcAddr[5:0]` with `pageWord` and keeps bits [10:6].
- R5: `jumpIndexed` loads `{pcAddr[10:6], accValue, 2'b00}`, which is one of 16 fixed words in the current page.
- R6: `callShort` loads `{5'b00000, shortImm}`. It pushes the sequential successor of the current address, computed under the wrap rule of R2.
- R7: `callLong` loads `targetLong` and pushes the sequential successor of the current address.
- R8: `intAck` pushes the current `pcAddr` unchanged and loads the parameter `INT_TARGET` (default 0x040).
- R9: `ret` loads the top stack entry into `pcAddr`. Each entry moves up one place and the bottom entry becomes 0x000.
- R10: A push moves every entry down one place. When the stack already holds three entries, the oldest is discarded.
- R11: A `ret` on an empty stack loads 0x000.
- R12: When a push command and `ret` are raised in the same cycle, the push is carried out and the `ret` is ignored. No entry is popped.
- R13: Among commands raised together, the priority is `intAck`, `callLong`, `callShort`, `jumpLong`, `jumpPage`, `jumpIndexed`, `ret`, `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Step to the next sequential address |
| jumpLong | input | 1 | Load the full target address |
| callLong | input | 1 | Push the return address and load the full target |
| targetLong | input | 11 | Target for a long jump or long call |
| jumpPage | input | 1 | Replace the word bits within the current page |
| pageWord | input | 6 | Word address for `jumpPage` |
| jumpIndexed | input | 1 | Jump to the word selected by the accumulator |
| accValue | input | 4 | Accumulator value for `jumpIndexed` |
| callShort | input | 1 | Push the return address and call into field 0, page 0 |
| shortImm | input | 6 | Word address for `callShort` |
| intAck | input | 1 | Interrupt acknowledge: push the current address and go to the vector |
| ret | input | 1 | Pop the top stack entry into the program counter |
| pcAddr | output | 11 | Current instruction address |
| stackEntries | output | 33 | Stack contents: entry k (0 is the top) in bits [11k+10:11k] |

## Verification
The advance is tried in three places: inside a page, across a page boundary, and at the end of the last page. These separate a full 11-bit increment from an 8-bit increment that leaves the field unchanged. The jump forms are run from addresses where the field and page bits differ, so an indexed or page jump that disturbs the upper bits is caught. The bench runs a chain of four pushes, then returns down to an empty stack and one return past it. This separates correct discarding of the oldest entry from corruption of the younger entries. Commands raised together are checked separately, including a push together with a return, to confirm the priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int FIELD_W = 3;
  localparam int PAGE_W  = 2;
  localparam int WORD_W  = 6;
  localparam int LOW_W   = PAGE_W + WORD_W;
  localparam int ADDR_W  = FIELD_W + LOW_W;
  localparam int IDX_W   = WORD_W - 2;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic loadFull;
    logic loadWord;
    logic loadIndex;
    logic loadShort;
    logic loadVector;
    logic loadPop;
    logic incr;
    logic push;
    logic pushHere;
    logic pop;
  } pcStrobe_t;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic      advance,
  input  logic      jumpLong,
  input  logic      callLong,
  input  logic      jumpPage,
  input  logic      jumpIndexed,
  input  logic      callShort,
  input  logic      intAck,
  input  logic      ret,
  output pcStrobe_t strb
);
  always_comb begin
    strb = '0;
    if (intAck) begin
      strb.loadVector = 1'b1;
      strb.push       = 1'b1;
      strb.pushHere   = 1'b1;
    end else if (callLong) begin
      strb.loadFull = 1'b1;
      strb.push     = 1'b1;
    end else if (callShort) begin
      strb.loadShort = 1'b1;
      strb.push      = 1'b1;
    end else if (jumpLong) begin
      strb.loadFull = 1'b1;
    end else if (jumpPage) begin
      strb.loadWord = 1'b1;
    end else if (jumpIndexed) begin
      strb.loadIndex = 1'b1;
    end else if (ret) begin
      strb.loadPop = 1'b1;
      strb.pop     = 1'b1;
    end else if (advance) begin
      strb.incr = 1'b1;
    end
  end
endmodule

// File: rtl/pcseq_path.sv
module pcseq_path
  import pcseq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] INT_TARGET = 11'h040
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strb,
  input  logic [ADDR_W-1:0] targetLong,
  input  logic [WORD_W-1:0] pageWord,
  input  logic [IDX_W-1:0]  accValue,
  input  logic [WORD_W-1:0] shortImm,
  input  logic [ADDR_W-1:0] popAddr,
  output logic [ADDR_W-1:0] pcAddr,
  output logic [ADDR_W-1:0] pushAddr
);
  logic [ADDR_W-1:0] pcQ, pcD, incAddr;

  // only the page/word counter steps; field bits ride along
  assign incAddr = {pcQ[ADDR_W-1:LOW_W],
                    pcQ[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1}};

  always_comb begin
    pcD = pcQ;
    if (strb.loadVector)     pcD = INT_TARGET;
    else if (strb.loadFull)  pcD = targetLong;
    else if (strb.loadShort) pcD = {{(ADDR_W-WORD_W){1'b0}}, shortImm};
    else if (strb.loadWord)  pcD = {pcQ[ADDR_W-1:WORD_W], pageWord};
    else if (strb.loadIndex) pcD = {pcQ[ADDR_W-1:WORD_W], accValue, 2'b00};
    else if (strb.loadPop)   pcD = popAddr;
    else if (strb.incr)      pcD = incAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcD;
  end

  assign pushAddr = strb.pushHere ? pcQ : incAddr;
  assign pcAddr   = pcQ;
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack
  import pcseq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      push,
  input  logic                      pop,
  input  logic [ADDR_W-1:0]         pushAddr,
  output logic [ADDR_W-1:0]         topAddr,
  output logic [DEPTH*ADDR_W-1:0]   entries
);
  logic [ADDR_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ADDR_W-1:0] fromAbove, fromBelow;
    if (i == 0) begin : g_top
      assign fromAbove = pushAddr;
    end else begin : g_mid
      assign fromAbove = slot[i-1];
    end
    if (i == DEPTH-1) begin : g_bot
      assign fromBelow = '0;
    end else begin : g_up
      assign fromBelow = slot[i+1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     slot[i] <= '0;
      else if (push) slot[i] <= fromAbove;
      else if (pop)  slot[i] <= fromBelow;
    end
    assign entries[i*ADDR_W +: ADDR_W] = slot[i];
  end

  assign topAddr = slot[0];
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int                DEPTH      = 3,
  parameter logic [ADDR_W-1:0] INT_TARGET = 11'h040
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    advance,
  input  logic                    jumpLong,
  input  logic                    callLong,
  input  logic [ADDR_W-1:0]       targetLong,
  input  logic                    jumpPage,
  input  logic [WORD_W-1:0]       pageWord,
  input  logic                    jumpIndexed,
  input  logic [IDX_W-1:0]        accValue,
  input  logic                    callShort,
  input  logic [WORD_W-1:0]       shortImm,
  input  logic                    intAck,
  input  logic                    ret,
  output logic [ADDR_W-1:0]       pcAddr,
  output logic [DEPTH*ADDR_W-1:0] stackEntries
);
  pcStrobe_t         strb;
  logic [ADDR_W-1:0] pushAddr, topAddr;

  pcseq_ctrl u_ctrl (
    .advance(advance), .jumpLong(jumpLong), .callLong(callLong),
    .jumpPage(jumpPage), .jumpIndexed(jumpIndexed), .callShort(callShort),
    .intAck(intAck), .ret(ret), .strb(strb)
  );

  pcseq_path #(.INT_TARGET(INT_TARGET)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .targetLong(targetLong),
    .pageWord(pageWord), .accValue(accValue), .shortImm(shortImm),
    .popAddr(topAddr), .pcAddr(pcAddr), .pushAddr(pushAddr)
  );

  pcseq_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rstN(rstN), .push(strb.push), .pop(strb.pop),
    .pushAddr(pushAddr), .topAddr(topAddr), .entries(stackEntries)
  );
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
  import pcseq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    advance,
  input logic                    jumpLong,
  input logic                    callLong,
  input logic [ADDR_W-1:0]       targetLong,
  input logic                    jumpPage,
  input logic                    jumpIndexed,
  input logic                    callShort,
  input logic                    intAck,
  input logic                    ret,
  input logic [ADDR_W-1:0]       pcAddr,
  input logic [DEPTH*ADDR_W-1:0] stackEntries
);
  logic anyPush, anyJump, noCmd;
  assign anyPush = intAck | callLong | callShort;
  assign anyJump = jumpLong | jumpPage | jumpIndexed;
  assign noCmd   = !(anyPush | anyJump | ret | advance);

  assert_adv_field_R2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !anyPush && !anyJump && !ret) |=>
      (pcAddr[ADDR_W-1:LOW_W] == $past(pcAddr[ADDR_W-1:LOW_W]) &&
       pcAddr[LOW_W-1:0] == $past(pcAddr[LOW_W-1:0]) + 8'd1));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    noCmd |=> $stable(pcAddr));

  assert_long_jump_R3: assert property (@(posedge clk) disable iff (!rstN)
    (jumpLong && !anyPush) |=> pcAddr == $past(targetLong));

  assert_page_keep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (jumpPage && !anyPush && !jumpLong) |=>
      pcAddr[ADDR_W-1:WORD_W] == $past(pcAddr[ADDR_W-1:WORD_W]));

  assert_return_top_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ret && !anyPush && !anyJump) |=> pcAddr == $past(stackEntries[ADDR_W-1:0]));

  assert_push_shift_R10: assert property (@(posedge clk) disable iff (!rstN)
    anyPush |=> stackEntries[2*ADDR_W-1:ADDR_W] == $past(stackEntries[ADDR_W-1:0]));

  assert_call_push_R7: assert property (@(posedge clk) disable iff (!rstN)
    (callLong && !intAck) |=>
      stackEntries[ADDR_W-1:0] ==
        {$past(pcAddr[ADDR_W-1:LOW_W]), $past(pcAddr[LOW_W-1:0]) + 8'd1});
endmodule

bind pc_sequencer pcseq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .advance(advance), .jumpLong(jumpLong),
  .callLong(callLong), .targetLong(targetLong), .jumpPage(jumpPage),
  .jumpIndexed(jumpIndexed), .callShort(callShort), .intAck(intAck),
  .ret(ret), .pcAddr(pcAddr), .stackEntries(stackEntries)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam logic [10:0] VEC = 11'h040;

  typedef struct packed {
    logic advance, jumpLong, callLong, jumpPage, jumpIndexed, callShort, intAck, ret;
    logic [10:0] tgt;
    logic [5:0]  word;
    logic [3:0]  acc;
    logic [5:0]  imm;
  } cmd_t;

  logic        clk = 0, rstN = 0;
  logic        advance = 0, jumpLong = 0, callLong = 0, jumpPage = 0;
  logic        jumpIndexed = 0, callShort = 0, intAck = 0, ret = 0;
  logic [10:0] targetLong = '0;
  logic [5:0]  pageWord = '0, shortImm = '0;
  logic [3:0]  accValue = '0;
  logic [10:0] pcAddr;
  logic [32:0] stackEntries;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [10:0] mPc  = '0;
  logic [32:0] mStk = '0;
  logic [10:0] expPc[$];
  logic [32:0] expStk[$];
  string       expTag[$];

  always #4 clk = ~clk;

  pc_sequencer #(.INT_TARGET(VEC)) dut (
    .clk(clk), .rstN(rstN), .advance(advance), .jumpLong(jumpLong),
    .callLong(callLong), .targetLong(targetLong), .jumpPage(jumpPage),
    .pageWord(pageWord), .jumpIndexed(jumpIndexed), .accValue(accValue),
    .callShort(callShort), .shortImm(shortImm), .intAck(intAck), .ret(ret),
    .pcAddr(pcAddr), .stackEntries(stackEntries)
  );

  // driver: apply one command and queue the expected state after the edge
  task automatic drive(input cmd_t c, input string tag);
    logic [10:0] succ, pushVal;
    logic        doPush;
    @(negedge clk);
    advance = c.advance; jumpLong = c.jumpLong; callLong = c.callLong;
    jumpPage = c.jumpPage; jumpIndexed = c.jumpIndexed; callShort = c.callShort;
    intAck = c.intAck; ret = c.ret; targetLong = c.tgt; pageWord = c.word;
    accValue = c.acc; shortImm = c.imm;
    succ    = {mPc[10:8], mPc[7:0] + 8'd1};
    doPush  = c.intAck | c.callLong | c.callShort;
    pushVal = c.intAck ? mPc : succ;
    if (c.intAck)           mPc = VEC;
    else if (c.callLong)    mPc = c.tgt;
    else if (c.callShort)   mPc = {5'b0, c.imm};
    else if (c.jumpLong)    mPc = c.tgt;
    else if (c.jumpPage)    mPc = {mPc[10:6], c.word};
    else if (c.jumpIndexed) mPc = {mPc[10:6], c.acc, 2'b00};
    else if (c.ret) begin
      mPc  = mStk[10:0];
      mStk = {11'b0, mStk[32:11]};
    end else if (c.advance) mPc = succ;
    if (doPush) mStk = {mStk[21:0], pushVal};
    expPc.push_back(mPc);
    expStk.push_back(mStk);
    expTag.push_back(tag);
  endtask

  // monitor: compare right after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expPc.size() > 0) begin
        logic [10:0] ep;
        logic [32:0] es;
        string       t;
        ep = expPc.pop_front();
        es = expStk.pop_front();
        t  = expTag.pop_front();
        total++;
        if (pcAddr !== ep || stackEntries !== es) begin
          bad++;
          $display("FAIL %s: pc=%h exp=%h stack=%h exp=%h", t, pcAddr, ep, stackEntries, es);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cmd_t c;
    repeat (3) @(negedge clk);
    total++;
    if (pcAddr !== 11'h000 || stackEntries !== 33'h0) begin
      bad++;
      $display("FAIL R1: pc=%h exp=000 stack=%h exp=0", pcAddr, stackEntries);
    end
    rstN = 1;

    c = '0; c.advance = 1;
    for (int i = 0; i < 3; i++) drive(c, "R2 step");
    c = '0; c.jumpLong = 1; c.tgt = 11'h03F; drive(c, "R3 long");
    c = '0; c.advance = 1; drive(c, "R2 page carry");
    c = '0; c.jumpLong = 1; c.tgt = 11'h5FF; drive(c, "R3 long field");
    c = '0; c.advance = 1; drive(c, "R2 field wrap");
    c = '0; drive(c, "R2 idle hold");
    c = '0; c.jumpPage = 1; c.word = 6'h2A; drive(c, "R4 page jump");
    c = '0; c.jumpIndexed = 1; c.acc = 4'hB; drive(c, "R5 indexed");
    c = '0; c.callLong = 1; c.tgt = 11'h345; drive(c, "R7 long call");
    c = '0; c.callShort = 1; c.imm = 6'h11; drive(c, "R6 short call");
    c = '0; c.intAck = 1; drive(c, "R8 interrupt");
    c = '0; c.callLong = 1; c.tgt = 11'h7AA; drive(c, "R10 overflow");
    c = '0; c.ret = 1;
    for (int i = 0; i < 3; i++) drive(c, "R9 return");
    drive(c, "R11 empty pop");
    c = '0; c.jumpLong = 1; c.tgt = 11'h2FF; drive(c, "R3 setup");
    c = '0; c.callShort = 1; c.imm = 6'h03; drive(c, "R6 wrap successor");
    c = '0; c.callShort = 1; c.imm = 6'h05; c.ret = 1; drive(c, "R12 push over pop");
    c = '0; c.jumpLong = 1; c.jumpPage = 1; c.advance = 1; c.tgt = 11'h1C4; c.word = 6'h3F;
    drive(c, "R13 long over page");
    c = '0; c.intAck = 1; c.callLong = 1; c.tgt = 11'h6AB; drive(c, "R13 int over call");
    c = '0; c.jumpIndexed = 1; c.ret = 1; c.advance = 1; c.acc = 4'h3; drive(c, "R13 index over ret");
    c = '0; c.ret = 1; c.advance = 1; drive(c, "R13 ret over adv");
    c = '0; drive(c, "R2 idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule